// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block belongs to the operand stage of a small 16-bit word-addressed processor. An instruction has a source operand and a destination operand, and each has a 6-bit mode field. For both fields the block reports where the operand lives: a register selector, a memory address, or an immediate value. It also reports the side effects the fields imply: how many extension words follow the opcode word, how far the stack pointer moves, and how many extra cycles the operand fetch costs.

The caller supplies the eight general registers, the stack pointer, the program counter and one extension word per operand. The source field is decoded first. The destination field then sees the stack pointer as the source left it, so a pop followed by a push addresses the same slot. The block does not touch memory or the register file and executes nothing. Its results are registered and appear one clock after a request.

Top module: `opnd_mode_decoder`

## Requirements
- R1: Mode codes 0x00 to 0x07 report kind REG with a register selector equal to the code. Kind is encoded NONE=0, REG=1, RAM=2.
- R2: Codes 0x08 to 0x0f report kind RAM at the value of general register (code & 7) and consume no extension word.
- R3: Codes 0x10 to 0x17 report kind RAM at that operand's extension word plus general register (code & 7). They add one word to the PC advance and one extra cycle.
- R4: Code 0x18 as destination is a push: the address is SP-1 and the SP moves by -1. As source it is a pop: the address is SP and the SP moves by +1. Addresses wrap modulo 2^16.
- R5: Code 0x19 reports RAM at SP with no SP change. Code 0x1a reports RAM at SP plus the extension word, with one word and one extra cycle.
- R6: Codes 0x1b, 0x1c and 0x1d report kind REG with selectors 8 (stack pointer), 9 (program counter) and 10 (overflow register).
- R7: Code 0x1e reports RAM at the extension word. Code 0x1f reports kind NONE with the extension word as its literal. Each costs one word and one extra cycle.
- R8: Codes 0x20 to 0x3f report kind NONE with literal (code & 0x1f) - 1 modulo 2^16, so 0x20 gives 0xffff and 0x3f gives 0x001e.
- R9: A literal target reports kind NONE, never REG or RAM, on either operand. This covers codes 0x1f and 0x20 to 0x3f used as destination, so a literal target never causes a write.
- R10: The PC advance (0 to 2), the extra cycle count (0 to 2) and the signed 2-bit SP delta (-1 encoded 2'b11) are sums over both operands. The destination is decoded with SP plus the source's delta. pc_next = pc_in + PC advance and sp_next = sp_in + SP delta.
- R11: All outputs are registered. out_valid is high exactly one clock after in_valid was sampled high. Reset clears out_valid and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_mode | input | 6 | Source operand mode field |
| dst_mode | input | 6 | Destination operand mode field |
| gpr_flat | input | 128 | Eight general registers, register i in bits [16i+15:16i] |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter after the opcode word |
| src_ext | input | 16 | Extension word for the source operand |
| dst_ext | input | 16 | Extension word for the destination operand |
| out_valid | output | 1 | Results valid |
| src_kind | output | 2 | Source target kind |
| src_sel | output | 4 | Source register selector |
| src_addr | output | 16 | Source memory address |
| src_lit | output | 16 | Source literal value |
| dst_kind | output | 2 | Destination target kind |
| dst_sel | output | 4 | Destination register selector |
| dst_addr | output | 16 | Destination memory address |
| dst_lit | output | 16 | Destination literal value |
| pc_adv | output | 2 | Extension words consumed |
| sp_delta | output | 2 | Signed stack pointer change |
| extra_cyc | output | 2 | Extra cycles for operand fetch |
| pc_next | output | 16 | PC after the extension words |
| sp_next | output | 16 | SP after both operand adjustments |

## Verification
The assertions assume in_valid and the mode fields are driven to known values whenever reset is released. They also assume the sampled inputs stay unchanged during the clock in which they are captured. The stack-pointer check relies on sp_in from the request cycle, so it also assumes that a result always follows its own request. The stimulus meets these assumptions by changing inputs only on the falling edge and by holding in_valid low during reset. It uses fixed register, stack and extension values, so every address in the expected table can be worked out by hand. Separate directed cases cover stack pointer wrap at 0x0000 and at 0xffff.

// File: rtl/opnd_dec_pkg.sv
package opnd_dec_pkg;
   localparam int MODE_W = 6;
   localparam int SEL_W  = 4;
   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      TK_NONE = 2'd0,
      TK_REG  = 2'd1,
      TK_RAM  = 2'd2
   } tgt_kind_e;

   localparam logic [SEL_W-1:0] SEL_SP = 4'd8;
   localparam logic [SEL_W-1:0] SEL_PC = 4'd9;
   localparam logic [SEL_W-1:0] SEL_EX = 4'd10;

   localparam logic [MODE_W-1:0] M_STACK = 6'h18;
   localparam logic [MODE_W-1:0] M_PEEK  = 6'h19;
   localparam logic [MODE_W-1:0] M_PICK  = 6'h1a;
   localparam logic [MODE_W-1:0] M_SPREG = 6'h1b;
   localparam logic [MODE_W-1:0] M_PCREG = 6'h1c;
   localparam logic [MODE_W-1:0] M_EXREG = 6'h1d;
   localparam logic [MODE_W-1:0] M_IND   = 6'h1e;
   localparam logic [MODE_W-1:0] M_IMM   = 6'h1f;
endpackage

// File: rtl/opnd_field_dec.sv
module opnd_field_dec
   import opnd_dec_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int NUM_GPR = 8
) (
   input  logic                      is_src,
   input  logic [MODE_W-1:0]         mode,
   input  logic [NUM_GPR*WORD_W-1:0] gpr_flat,
   input  logic [WORD_W-1:0]         sp_eff,
   input  logic [WORD_W-1:0]         ext_word,
   output logic [KIND_W-1:0]         kind,
   output logic [SEL_W-1:0]          sel,
   output logic [WORD_W-1:0]         addr,
   output logic [WORD_W-1:0]         lit,
   output logic                      uses_ext,
   output logic [1:0]                sp_step
);
   localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};
   localparam int IDX_W = $clog2(NUM_GPR);

   logic [IDX_W-1:0]  gidx;
   logic [WORD_W-1:0] gval;
   logic [WORD_W-1:0] short_lit;

   assign gidx      = mode[IDX_W-1:0];
   assign gval      = gpr_flat[gidx*WORD_W +: WORD_W];
   assign short_lit = {{(WORD_W-5){1'b0}}, mode[4:0]} - ONE_W;

   always_comb begin
      kind     = TK_NONE;
      sel      = '0;
      addr     = '0;
      lit      = '0;
      uses_ext = 1'b0;
      sp_step  = 2'b00;
      if (mode[5]) begin
         lit = short_lit;
      end else if (mode[4:3] == 2'b00) begin
         kind = TK_REG;
         sel  = {{(SEL_W-IDX_W){1'b0}}, gidx};
      end else if (mode[4:3] == 2'b01) begin
         kind = TK_RAM;
         addr = gval;
      end else if (mode[4:3] == 2'b10) begin
         kind     = TK_RAM;
         addr     = ext_word + gval;
         uses_ext = 1'b1;
      end else begin
         unique case (mode)
            M_STACK: begin
               kind = TK_RAM;
               if (is_src) begin
                  addr    = sp_eff;
                  sp_step = 2'b01;
               end else begin
                  addr    = sp_eff - ONE_W;
                  sp_step = 2'b11;
               end
            end
            M_PEEK: begin
               kind = TK_RAM;
               addr = sp_eff;
            end
            M_PICK: begin
               kind     = TK_RAM;
               addr     = sp_eff + ext_word;
               uses_ext = 1'b1;
            end
            M_SPREG: begin
               kind = TK_REG;
               sel  = SEL_SP;
            end
            M_PCREG: begin
               kind = TK_REG;
               sel  = SEL_PC;
            end
            M_EXREG: begin
               kind = TK_REG;
               sel  = SEL_EX;
            end
            M_IND: begin
               kind     = TK_RAM;
               addr     = ext_word;
               uses_ext = 1'b1;
            end
            default: begin
               lit      = ext_word;
               uses_ext = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/opnd_out_stage.sv
module opnd_out_stage #(
   parameter int DATA_W     = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (REGISTERED) begin : g_reg
         logic              v_q;
         logic [DATA_W-1:0] d_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= in_valid;
               if (in_valid) d_q <= in_data;
            end
         end
         assign out_valid = v_q;
         assign out_data  = d_q;
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end
   endgenerate
endmodule

// File: rtl/opnd_mode_decoder.sv
module opnd_mode_decoder
   import opnd_dec_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int NUM_GPR = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [5:0]                src_mode,
   input  logic [5:0]                dst_mode,
   input  logic [NUM_GPR*WORD_W-1:0] gpr_flat,
   input  logic [WORD_W-1:0]         sp_in,
   input  logic [WORD_W-1:0]         pc_in,
   input  logic [WORD_W-1:0]         src_ext,
   input  logic [WORD_W-1:0]         dst_ext,
   output logic                      out_valid,
   output logic [1:0]                src_kind,
   output logic [3:0]                src_sel,
   output logic [WORD_W-1:0]         src_addr,
   output logic [WORD_W-1:0]         src_lit,
   output logic [1:0]                dst_kind,
   output logic [3:0]                dst_sel,
   output logic [WORD_W-1:0]         dst_addr,
   output logic [WORD_W-1:0]         dst_lit,
   output logic [1:0]                pc_adv,
   output logic [1:0]                sp_delta,
   output logic [1:0]                extra_cyc,
   output logic [WORD_W-1:0]         pc_next,
   output logic [WORD_W-1:0]         sp_next
);
   localparam int SIDE_W = KIND_W + SEL_W + 2*WORD_W;
   localparam int DATA_W = 2*SIDE_W + 6 + 2*WORD_W;

   generate
      if (NUM_GPR != 8) begin : g_bad_gpr
         $error("NUM_GPR must be 8: mode codes pick registers with three bits");
      end
      if (WORD_W < 8) begin : g_bad_word
         $error("WORD_W must hold the short literal range");
      end
   endgenerate

   // Per-operand decode results, index 0 = source, 1 = destination
   logic [KIND_W-1:0] kind_v   [2];
   logic [SEL_W-1:0]  sel_v    [2];
   logic [WORD_W-1:0] addr_v   [2];
   logic [WORD_W-1:0] lit_v    [2];
   logic              ext_v    [2];
   logic [1:0]        step_v   [2];
   logic [WORD_W-1:0] sp_seen  [2];
   logic [MODE_W-1:0] mode_v   [2];
   logic [WORD_W-1:0] word_v   [2];

   assign mode_v[0]  = src_mode;
   assign mode_v[1]  = dst_mode;
   assign word_v[0]  = src_ext;
   assign word_v[1]  = dst_ext;
   assign sp_seen[0] = sp_in;
   assign sp_seen[1] = sp_in + {{(WORD_W-2){step_v[0][1]}}, step_v[0]};

   generate
      for (genvar k = 0; k < 2; k++) begin : g_side
         opnd_field_dec #(
            .WORD_W  (WORD_W),
            .NUM_GPR (NUM_GPR)
         ) u_dec (
            .is_src   (k == 0),
            .mode     (mode_v[k]),
            .gpr_flat (gpr_flat),
            .sp_eff   (sp_seen[k]),
            .ext_word (word_v[k]),
            .kind     (kind_v[k]),
            .sel      (sel_v[k]),
            .addr     (addr_v[k]),
            .lit      (lit_v[k]),
            .uses_ext (ext_v[k]),
            .sp_step  (step_v[k])
         );
      end
   endgenerate

   logic [1:0]        adv_c;
   logic [1:0]        cyc_c;
   logic [1:0]        dsp_c;
   logic [WORD_W-1:0] pcn_c;
   logic [WORD_W-1:0] spn_c;

   assign adv_c = {1'b0, ext_v[0]} + {1'b0, ext_v[1]};
   // Each extension fetch costs a memory cycle; counted from the fetch flags
   assign cyc_c = {1'b0, ext_v[0] & (mode_v[0][4:3] != 2'b00 || mode_v[0][5] == 1'b0)}
                + {1'b0, ext_v[1] & (mode_v[1][4:3] != 2'b00 || mode_v[1][5] == 1'b0)};
   assign dsp_c = step_v[0] + step_v[1];
   assign pcn_c = pc_in + {{(WORD_W-2){1'b0}}, adv_c};
   assign spn_c = sp_in + {{(WORD_W-2){dsp_c[1]}}, dsp_c};

   logic [DATA_W-1:0] pack_in;
   logic [DATA_W-1:0] pack_out;

   assign pack_in = {kind_v[0], sel_v[0], addr_v[0], lit_v[0],
                     kind_v[1], sel_v[1], addr_v[1], lit_v[1],
                     adv_c, dsp_c, cyc_c, pcn_c, spn_c};

   opnd_out_stage #(
      .DATA_W     (DATA_W),
      .REGISTERED (OUT_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (pack_in),
      .out_valid (out_valid),
      .out_data  (pack_out)
   );

   assign {src_kind, src_sel, src_addr, src_lit,
           dst_kind, dst_sel, dst_addr, dst_lit,
           pc_adv, sp_delta, extra_cyc, pc_next, sp_next} = pack_out;
endmodule

// File: rtl/opnd_mode_decoder_chk.sv
module opnd_mode_decoder_chk #(
   parameter int WORD_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [5:0]        src_mode,
   input logic [5:0]        dst_mode,
   input logic [WORD_W-1:0] sp_in,
   input logic              out_valid,
   input logic [1:0]        src_kind,
   input logic [3:0]        src_sel,
   input logic [1:0]        dst_kind,
   input logic [1:0]        pc_adv,
   input logic [1:0]        sp_delta,
   input logic [1:0]        extra_cyc,
   input logic [WORD_W-1:0] sp_next
);
   generate
      if (OUT_REG) begin : g_seq
         AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R11
         AST_GPR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && src_mode < 6'h08 |=>
               src_kind == 2'd1 && src_sel == {1'b0, $past(src_mode[2:0])}); // R1
         AST_DST_LIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && dst_mode >= 6'h1f |=> dst_kind == 2'd0); // R9
         AST_SRC_LIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && src_mode >= 6'h20 |=> src_kind == 2'd0); // R8
         AST_SP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> sp_next == $past(sp_in) + {{(WORD_W-2){sp_delta[1]}}, sp_delta}); // R10
         AST_CYCLES_TRACK_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> extra_cyc == pc_adv); // R10
         AST_PUSH_POP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && src_mode != 6'h18 && dst_mode != 6'h18 |=> sp_delta == 2'b00); // R4
      end
   endgenerate
endmodule

bind opnd_mode_decoder opnd_mode_decoder_chk #(
   .WORD_W  (WORD_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .src_mode  (src_mode),
   .dst_mode  (dst_mode),
   .sp_in     (sp_in),
   .out_valid (out_valid),
   .src_kind  (src_kind),
   .src_sel   (src_sel),
   .dst_kind  (dst_kind),
   .pc_adv    (pc_adv),
   .sp_delta  (sp_delta),
   .extra_cyc (extra_cyc),
   .sp_next   (sp_next)
);

// File: tb/opnd_mode_decoder_test.sv
module opnd_mode_decoder_test;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [5:0]    src_mode = '0;
   logic [5:0]    dst_mode = '0;
   logic [8*W-1:0] gpr_flat;
   logic [W-1:0]  sp_in = 16'h8000;
   logic [W-1:0]  pc_in = 16'h0200;
   logic [W-1:0]  src_ext = 16'h0040;
   logic [W-1:0]  dst_ext = 16'h0300;
   logic          out_valid;
   logic [1:0]    src_kind, dst_kind, pc_adv, sp_delta, extra_cyc;
   logic [3:0]    src_sel, dst_sel;
   logic [W-1:0]  src_addr, src_lit, dst_addr, dst_lit, pc_next, sp_next;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_gpr
      assign gpr_flat[i*W +: W] = 16'h1000 + 16'(i * 16);
   end

   opnd_mode_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_mode(src_mode), .dst_mode(dst_mode), .gpr_flat(gpr_flat),
      .sp_in(sp_in), .pc_in(pc_in), .src_ext(src_ext), .dst_ext(dst_ext),
      .out_valid(out_valid), .src_kind(src_kind), .src_sel(src_sel),
      .src_addr(src_addr), .src_lit(src_lit), .dst_kind(dst_kind),
      .dst_sel(dst_sel), .dst_addr(dst_addr), .dst_lit(dst_lit),
      .pc_adv(pc_adv), .sp_delta(sp_delta), .extra_cyc(extra_cyc),
      .pc_next(pc_next), .sp_next(sp_next)
   );

   typedef struct packed {
      logic [5:0]  sm;
      logic [5:0]  dm;
      logic [1:0]  sk;
      logic [3:0]  ss;
      logic [15:0] sa;
      logic [15:0] sl;
      logic [1:0]  dk;
      logic [3:0]  ds;
      logic [15:0] da;
      logic [15:0] dl;
      logic [1:0]  adv;
      logic [1:0]  dsp;
   } vec_t;

   // gpr i = 0x1000 + 16*i, SP 0x8000, PC 0x0200, ext words 0x0040 / 0x0300
   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{6'h03, 6'h05, 2'd1, 4'd3,  16'h0000, 16'h0000, 2'd1, 4'd5,  16'h0000, 16'h0000, 2'd0, 2'b00}, // R1
      '{6'h0a, 6'h0f, 2'd2, 4'd0,  16'h1020, 16'h0000, 2'd2, 4'd0,  16'h1070, 16'h0000, 2'd0, 2'b00}, // R2
      '{6'h11, 6'h16, 2'd2, 4'd0,  16'h1050, 16'h0000, 2'd2, 4'd0,  16'h1360, 16'h0000, 2'd2, 2'b00}, // R3
      '{6'h18, 6'h18, 2'd2, 4'd0,  16'h8000, 16'h0000, 2'd2, 4'd0,  16'h8000, 16'h0000, 2'd0, 2'b00}, // R4
      '{6'h19, 6'h18, 2'd2, 4'd0,  16'h8000, 16'h0000, 2'd2, 4'd0,  16'h7fff, 16'h0000, 2'd0, 2'b11}, // R5
      '{6'h1a, 6'h19, 2'd2, 4'd0,  16'h8040, 16'h0000, 2'd2, 4'd0,  16'h8000, 16'h0000, 2'd1, 2'b00}, // R5
      '{6'h1b, 6'h1c, 2'd1, 4'd8,  16'h0000, 16'h0000, 2'd1, 4'd9,  16'h0000, 16'h0000, 2'd0, 2'b00}, // R6
      '{6'h1d, 6'h1e, 2'd1, 4'd10, 16'h0000, 16'h0000, 2'd2, 4'd0,  16'h0300, 16'h0000, 2'd1, 2'b00}, // R6 R7
      '{6'h1f, 6'h1f, 2'd0, 4'd0,  16'h0000, 16'h0040, 2'd0, 4'd0,  16'h0000, 16'h0300, 2'd2, 2'b00}, // R7 R9
      '{6'h20, 6'h21, 2'd0, 4'd0,  16'h0000, 16'hffff, 2'd0, 4'd0,  16'h0000, 16'h0000, 2'd0, 2'b00}, // R8 R9
      '{6'h3f, 6'h00, 2'd0, 4'd0,  16'h0000, 16'h001e, 2'd1, 4'd0,  16'h0000, 16'h0000, 2'd0, 2'b00}, // R8
      '{6'h18, 6'h1a, 2'd2, 4'd0,  16'h8000, 16'h0000, 2'd2, 4'd0,  16'h8301, 16'h0000, 2'd1, 2'b01}  // R10
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] sm, input logic [5:0] dm);
      @(negedge clk);
      src_mode = sm;
      dst_mode = dm;
      in_valid = 1'b1;
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R11", "reset src_addr", {16'd0, src_addr}, 32'd0);
      check("R11", "reset sp_next", {16'd0, sp_next}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VT[i].sm, VT[i].dm);
         check("R11", $sformatf("v%0d out_valid", i), {31'd0, out_valid}, 32'd1);
         check("R1-R9", $sformatf("v%0d src_kind", i), {30'd0, src_kind}, {30'd0, VT[i].sk});
         check("R1 R6", $sformatf("v%0d src_sel", i), {28'd0, src_sel}, {28'd0, VT[i].ss});
         check("R2 R3", $sformatf("v%0d src_addr", i), {16'd0, src_addr}, {16'd0, VT[i].sa});
         check("R7 R8", $sformatf("v%0d src_lit", i), {16'd0, src_lit}, {16'd0, VT[i].sl});
         check("R9", $sformatf("v%0d dst_kind", i), {30'd0, dst_kind}, {30'd0, VT[i].dk});
         check("R1 R6", $sformatf("v%0d dst_sel", i), {28'd0, dst_sel}, {28'd0, VT[i].ds});
         check("R4 R5", $sformatf("v%0d dst_addr", i), {16'd0, dst_addr}, {16'd0, VT[i].da});
         check("R7", $sformatf("v%0d dst_lit", i), {16'd0, dst_lit}, {16'd0, VT[i].dl});
         check("R10", $sformatf("v%0d pc_adv", i), {30'd0, pc_adv}, {30'd0, VT[i].adv});
         check("R10", $sformatf("v%0d extra_cyc", i), {30'd0, extra_cyc}, {30'd0, VT[i].adv});
         check("R10", $sformatf("v%0d sp_delta", i), {30'd0, sp_delta}, {30'd0, VT[i].dsp});
         check("R10", $sformatf("v%0d pc_next", i), {16'd0, pc_next},
               {16'd0, 16'h0200 + {14'd0, VT[i].adv}});
         check("R10", $sformatf("v%0d sp_next", i), {16'd0, sp_next},
               {16'd0, 16'h8000 + {{14{VT[i].dsp[1]}}, VT[i].dsp}});
      end

      // R4: push wraps below zero
      sp_in = 16'h0000;
      apply(6'h00, 6'h18);
      check("R4", "push wrap addr", {16'd0, dst_addr}, 32'h0000ffff);
      check("R4", "push wrap sp_next", {16'd0, sp_next}, 32'h0000ffff);

      // R4: pop wraps above top
      sp_in = 16'hffff;
      apply(6'h18, 6'h00);
      check("R4", "pop wrap addr", {16'd0, src_addr}, 32'h0000ffff);
      check("R4", "pop wrap sp_next", {16'd0, sp_next}, 32'h00000000);

      // R11: no request, no valid
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      #2;
      check("R11", "idle out_valid", {31'd0, out_valid}, 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule